// File: doc/BRIEF.md
# Multi-mode video timing generator

This block produces the raster timing for a display link running at 60 Hz in one of four standard resolutions: 640x480, 800x600, 1280x720 and 1920x1080. It runs from the system clock and advances one pixel position on each cycle where the pixel-clock enable is high. It drives horizontal and vertical sync at the polarity the selected mode requires. It also drives a data-enable that marks the visible area, the current column and row, and single-enable pulses that mark the start of each line and of each frame.

A 2-bit mode input selects the resolution. The block takes a new value from this input only on the final pixel of a frame, so every frame it emits is complete and well formed. The per-mode timing table is a parameter. Its default holds the four standard modes, and a smaller table can be used for fast simulation.

Top module: `vid_timing_gen`

## Requirements
- R1: Each line runs active pixels, then front porch, then sync, then back porch. The horizontal sync is asserted exactly on columns from active+front porch up to, but not including, active+front porch+sync width.
- R2: Each frame is ordered the same way in lines. The vertical sync is asserted exactly on rows from active+front porch up to, but not including, active+front porch+sync width.
- R3: Mode 0 drives both syncs active-low, so the pins sit at 1 when idle. Modes 1, 2 and 3 drive both syncs active-high.
- R4: The column advances by one only on cycles where pix_en_i is 1. After the mode's last pixel (total-1) it wraps to 0.
- R5: The row advances by one only when the column wraps. After the mode's last line it wraps to 0.
- R6: de_o is 1 exactly when column < active pixels and row < active lines. While de_o is 1, col_o and row_o give the visible pixel position. Neither sync is ever asserted while de_o is 1.
- R7: mode_i is sampled only on an enabled cycle at the last column of the last row. At that point the counters restart at 0 with the new mode's timing and polarity. A change of mode_i at any other time has no effect.
- R8: sol_o equals pix_en_i while the column is 0. sof_o equals pix_en_i while both the column and the row are 0.
- R9: While rst_ni is 0, the block is in mode 0, col_o and row_o are 0, and both syncs sit at their idle level of 1.
- R10: The default table encodes the following modes. Mode 0: 640/16/96/48 by 480/10/2/33. Mode 1: 800/40/128/88 by 600/1/4/23. Mode 2: 1280/110/40/220 by 720/5/5/20. Mode 3: 1920/88/44/148 by 1080/4/5/36. Each group is active/front/sync/back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable; one pixel per high cycle |
| mode_i | input | 2 | Requested mode 0..3, taken at frame end |
| hsync_o | output | 1 | Horizontal sync, polarity per mode |
| vsync_o | output | 1 | Vertical sync, polarity per mode |
| de_o | output | 1 | Visible-area data enable |
| col_o | output | 12 | Current column |
| row_o | output | 12 | Current row |
| sol_o | output | 1 | Start-of-line pulse |
| sof_o | output | 1 | Start-of-frame pulse |

## Verification
The main check uses a scaled-down timing table, so that many full frames fit in a short run. Under a pixel enable that is randomly gapped, stalls show up as counter holds, and gaps at the last pixel show whether the frame end is qualified by the enable. mode_i changes at random points in the frame, which checks that mode switches happen only at the frame boundary and that polarity flips along with the new geometry. A mid-run reset checks the return to mode 0. A second instance with the default table runs the first lines of mode 0 at full rate, which confirms the standard 640x480 horizontal numbers and the active-low sync.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned CW        = 12;
  localparam int unsigned NUM_MODES = 4;
  localparam int unsigned MW        = $clog2(NUM_MODES);

  typedef struct packed {
    logic          pol;    // 1: active-high syncs
    logic [CW-1:0] h_act;
    logic [CW-1:0] h_fp;
    logic [CW-1:0] h_sw;
    logic [CW-1:0] h_bp;
    logic [CW-1:0] v_act;
    logic [CW-1:0] v_fp;
    logic [CW-1:0] v_sw;
    logic [CW-1:0] v_bp;
  } timing_t;

  typedef timing_t [NUM_MODES-1:0] tbl_t;

  localparam tbl_t STD_TBL = '{
    3: '{1'b1, 12'd1920, 12'd88,  12'd44,  12'd148, 12'd1080, 12'd4,  12'd5, 12'd36},
    2: '{1'b1, 12'd1280, 12'd110, 12'd40,  12'd220, 12'd720,  12'd5,  12'd5, 12'd20},
    1: '{1'b1, 12'd800,  12'd40,  12'd128, 12'd88,  12'd600,  12'd1,  12'd4, 12'd23},
    0: '{1'b0, 12'd640,  12'd16,  12'd96,  12'd48,  12'd480,  12'd10, 12'd2, 12'd33}
  };
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] fp_i,
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] bp_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o,
  output logic         active_o,
  output logic         in_sync_o
);
  localparam int unsigned SW = W + 2;

  logic [SW-1:0] sync_beg, sync_end, total;
  logic [W-1:0]  cnt_q;

  assign sync_beg = SW'(act_i) + SW'(fp_i);
  assign sync_end = sync_beg + SW'(sw_i);
  assign total    = sync_end + SW'(bp_i);

  assign last_o    = (SW'(cnt_q) == total - SW'(1));
  assign active_o  = (cnt_q < act_i);
  assign in_sync_o = (SW'(cnt_q) >= sync_beg) && (SW'(cnt_q) < sync_end);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/vtg_mode_reg.sv
module vtg_mode_reg #(
  parameter int unsigned MW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [MW-1:0] mode_i,
  output logic [MW-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= '0;
    else if (load_i) mode_o <= mode_i;
  end
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter vtg_pkg::tbl_t MODE_TBL = vtg_pkg::STD_TBL
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pix_en_i,
  input  logic [vtg_pkg::MW-1:0] mode_i,
  output logic                   hsync_o,
  output logic                   vsync_o,
  output logic                   de_o,
  output logic [vtg_pkg::CW-1:0] col_o,
  output logic [vtg_pkg::CW-1:0] row_o,
  output logic                   sol_o,
  output logic                   sof_o
);
  import vtg_pkg::*;

  logic [MW-1:0] mode_q;
  timing_t       cur_t;
  logic          cur_pol;
  logic          h_last, h_act, h_sync;
  logic          v_last, v_act, v_sync;
  logic          line_end, frame_end;

  assign cur_t     = MODE_TBL[mode_q];
  assign cur_pol   = cur_t.pol;
  assign line_end  = pix_en_i & h_last;
  assign frame_end = line_end & v_last;

  vtg_mode_reg #(.MW(MW)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_end),
    .mode_i (mode_i),
    .mode_o (mode_q)
  );

  vtg_axis #(.W(CW)) u_h (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (pix_en_i),
    .act_i     (cur_t.h_act),
    .fp_i      (cur_t.h_fp),
    .sw_i      (cur_t.h_sw),
    .bp_i      (cur_t.h_bp),
    .cnt_o     (col_o),
    .last_o    (h_last),
    .active_o  (h_act),
    .in_sync_o (h_sync)
  );

  vtg_axis #(.W(CW)) u_v (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (line_end),
    .act_i     (cur_t.v_act),
    .fp_i      (cur_t.v_fp),
    .sw_i      (cur_t.v_sw),
    .bp_i      (cur_t.v_bp),
    .cnt_o     (row_o),
    .last_o    (v_last),
    .active_o  (v_act),
    .in_sync_o (v_sync)
  );

  // polarity: pin = pulse when active-high, inverted when active-low
  assign hsync_o = ~(h_sync ^ cur_pol);
  assign vsync_o = ~(v_sync ^ cur_pol);
  assign de_o    = h_act & v_act;
  assign sol_o   = pix_en_i & (col_o == '0);
  assign sof_o   = sol_o & (row_o == '0);
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pix_en_i,
  input logic        hsync_o,
  input logic        vsync_o,
  input logic        de_o,
  input logic [11:0] col_o,
  input logic [11:0] row_o,
  input logic        sol_o,
  input logic        sof_o,
  input logic [1:0]  mode_q,
  input logic        cur_pol
);
  a_r4_col_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(col_o));

  a_r5_row_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_o != $past(row_o)) |-> (col_o == 12'd0));

  a_r6_no_sync_in_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == ~cur_pol) && (vsync_o == ~cur_pol));

  a_r7_mode_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> (col_o == 12'd0) && (row_o == 12'd0));

  a_r8_sof_in_sol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> sol_o && de_o && pix_en_i);
endmodule

bind vid_timing_gen vid_timing_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pix_en_i (pix_en_i),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .de_o     (de_o),
  .col_o    (col_o),
  .row_o    (row_o),
  .sol_o    (sol_o),
  .sof_o    (sof_o),
  .mode_q   (mode_q),
  .cur_pol  (cur_pol)
);

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
  localparam vtg_pkg::tbl_t SMALL = '{
    3: '{1'b1, 12'd4,  12'd1, 12'd1, 12'd1, 12'd2, 12'd1, 12'd1, 12'd1},
    2: '{1'b1, 12'd10, 12'd3, 12'd1, 12'd4, 12'd5, 12'd1, 12'd1, 12'd3},
    1: '{1'b1, 12'd6,  12'd1, 12'd2, 12'd3, 12'd3, 12'd2, 12'd1, 12'd1},
    0: '{1'b0, 12'd8,  12'd2, 12'd3, 12'd2, 12'd4, 12'd1, 12'd2, 12'd2}
  };

  logic clk = 0, rst_n = 0, pen = 0;
  logic [1:0] mode = 0;
  logic hs, vs, de, sol, sof, s_hs, s_vs, s_de, s_sol, s_sof;
  logic [11:0] col, row, s_col, s_row;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vid_timing_gen #(.MODE_TBL(SMALL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pen), .mode_i(mode),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .col_o(col), .row_o(row),
    .sol_o(sol), .sof_o(sof));

  vid_timing_gen u_std (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(1'b1), .mode_i(2'd0),
    .hsync_o(s_hs), .vsync_o(s_vs), .de_o(s_de), .col_o(s_col), .row_o(s_row),
    .sol_o(s_sol), .sof_o(s_sof));

  // bench timing values: act, fp, sw, bp for h then v, and polarity
  function automatic int hv(int m, int idx);
    int t[4][8] = '{'{8,2,3,2,4,1,2,2}, '{6,1,2,3,3,2,1,1},
                    '{10,3,1,4,5,1,1,3}, '{4,1,1,1,2,1,1,1}};
    return t[m][idx];
  endfunction
  function automatic int tot(int m, int base);
    return hv(m,base) + hv(m,base+1) + hv(m,base+2) + hv(m,base+3);
  endfunction
  function automatic bit in_sync(int m, int base, int c);
    int b = hv(m,base) + hv(m,base+1);
    return (c >= b) && (c < b + hv(m,base+2));
  endfunction
  function automatic bit pin(int m, bit raw);
    return (m == 0) ? !raw : raw;   // R3: mode 0 active-low
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int mh = 0, mv = 0, mm = 0, sh = 0, sv = 0;

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 col", col, 0); chk("R9 row", row, 0);
    chk("R9 hsync", hs, 1); chk("R9 vsync", vs, 1);
    @(negedge clk); rst_n = 1;
    for (int cyc = 0; cyc < 24000; cyc++) begin
      @(negedge clk);
      if (cyc == 2000) begin
        pen = 1; rst_n = 0; #1;
        chk("R9 col", col, 0); chk("R9 row", row, 0);
        chk("R9 hsync", hs, 1); chk("R9 vsync", vs, 1);
        mh = 0; mv = 0; mm = 0; sh = 0; sv = 0;
        @(negedge clk); rst_n = 1;
      end
      if (cyc < 1000) pen = 0;
      else if (cyc < 1400) pen = 1;
      else pen = ($urandom % 4) != 0;
      if (($urandom % 23) == 0) mode = 2'($urandom);
      #1;
      // main instance
      chk((mode != 2'(mm)) ? "R7 col" : "R4 col", col, mh);
      chk((mode != 2'(mm)) ? "R7 row" : "R5 row", row, mv);
      chk("R6 de", de, int'(mh < hv(mm,0) && mv < hv(mm,4)));
      chk("R1/R3 hsync", hs, pin(mm, in_sync(mm,0,mh)));
      chk("R2/R3 vsync", vs, pin(mm, in_sync(mm,4,mv)));
      chk("R8 sol", sol, int'(pen && mh == 0));
      chk("R8 sof", sof, int'(pen && mh == 0 && mv == 0));
      if (pen) begin
        if (mh == tot(mm,0) - 1) begin
          mh = 0;
          if (mv == tot(mm,4) - 1) begin mv = 0; mm = mode; end
          else mv++;
        end else mh++;
      end
      // default-table instance, mode 0 at full rate, first lines only
      if (cyc >= 2000 && cyc < 3700) begin
        chk("R10 std col", s_col, sh);
        chk("R10 std row", s_row, sv);
        chk("R10 std hsync", s_hs, int'(!(sh >= 656 && sh < 752)));
        chk("R10 std de", s_de, int'(sh < 640));
      end
      if (sh == 799) begin sh = 0; sv++; end else sh++;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule